// File: doc/BRIEF.md
# Multi-Source Reset Controller

This block merges several independent reset causes into one stretched system reset and keeps an 8-bit cause register that software reads after reset to learn what happened. The causes are an active-low reset pin, a detector that notices the system clock has stopped, a checker that catches flash accesses beyond the user code limit or blocked by security, a software-forced reset, and a USB reset driven either by bus-reset signalling or by the VBUS level matching a configured polarity.

The controller runs on a free-running reference clock. The monitored system clock is treated as a plain signal: it is synchronised into the reference domain and its rising edges restart a timeout counter. Writes to the cause register do not set the read-back flags directly. Some bits arm a source (clock detector, USB), one bit fires a software reset, and every reset clears the register and sets only the bit of the cause that won. Asynchronous inputs (pin, USB bus reset, VBUS) pass through two-flop synchronisers.

Top module: `multi_reset_ctrl`

## Requirements
- R1: After `rst_ni` is released, `sys_rst_o` stays high for exactly STRETCH_CYCLES reference cycles and `status_o` reads 0x00.
- R2: While the synchronised pin is low, `sys_rst_o` is held high. After release it stays high for between STRETCH_CYCLES and STRETCH_CYCLES+4 cycles. `status_o` then reads 0x01 (bit 0).
- R3: A write with data bit 4 set, made while idle, raises `sys_rst_o` in the next cycle for exactly STRETCH_CYCLES cycles. `status_o` then reads 0x10. No reset is ever shorter than STRETCH_CYCLES cycles.
- R4: A flash write, code-space read or fetch to an address above FLASH_TOP (default 0x3DFF), or a security block strobe, raises `sys_rst_o` in the next cycle. `status_o` then reads 0x40 (bit 6). An access at exactly FLASH_TOP or below causes no reset.
- R5: Writing 1 to bit 2 arms the clock detector, and writing 0 to bit 2 disarms it. When armed, MCD_LIMIT reference cycles with no rising edge of `sys_clk_i` cause a reset with `status_o` = 0x04. A running system clock or a disarmed detector causes no reset.
- R6: Writing 1 to bit 3 arms the USB source. When armed, a bus-reset indication, or `usb_vbus_i` equal to `usb_vbus_pol_i`, causes a reset with `status_o` = 0x08. When not armed, neither has any effect.
- R7: At most one bit of `status_o` is set. `status_o` changes only while `sys_rst_o` is high. A write of 1s to bits 0 and 6 leaves `status_o` unchanged.
- R8: When causes coincide, the order is pin, then clock detector, then flash, then USB, then software. A flash error in the same cycle as a software write reports 0x40. A pin assertion during an internal reset extends the reset and changes `status_o` to 0x01.
- R9: Every reset disarms the clock detector and the USB source. A stopped system clock after a detector reset causes no further reset.
- R10: Register writes made while `sys_rst_o` is high are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running reference clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| sys_clk_i | input | 1 | System clock being monitored |
| pin_rst_ni | input | 1 | External reset pin, active low, asynchronous |
| reg_wr_i | input | 1 | Write strobe for the cause/control register |
| reg_wdata_i | input | 8 | Write data |
| fl_wr_i | input | 1 | Flash write/erase request with write enable set |
| fl_rd_i | input | 1 | Data read from code space |
| fl_fetch_i | input | 1 | Program fetch or branch target |
| fl_addr_i | input | ADDR_W | Flash access address |
| fl_sec_i | input | 1 | Access blocked by security setting |
| usb_bus_rst_i | input | 1 | USB bus-reset signalling detected (asynchronous) |
| usb_vbus_i | input | 1 | VBUS level (asynchronous) |
| usb_vbus_pol_i | input | 1 | VBUS polarity that triggers a reset |
| sys_rst_o | output | 1 | Stretched system reset, active high |
| status_o | output | 8 | Cause register read value |

## Verification
A vector table drives flash accesses of each kind just above and exactly at the address limit, security strobes, and software writes with and without the fire bit. Together these separate a wrong comparison boundary from a wrong flag position. Combined vectors, with a flash error and a software fire in the same cycle, and a pin pulled low during a software reset, show whether the priority order and pin override are right. The clock detector is driven with a running clock, a stopped clock, a disarmed state and a post-reset state. These separate the timeout itself from the arming and disarming logic. USB tests compare bus reset and VBUS match in the armed and unarmed states, and a write made during reset shows whether writes are blocked then.

// File: rtl/rsc_pkg.sv
package rsc_pkg;

    localparam int unsigned FLAG_W    = 8;
    // Bit positions software depends on
    localparam int unsigned BIT_PIN   = 0;
    localparam int unsigned BIT_MCD   = 2;
    localparam int unsigned BIT_USB   = 3;
    localparam int unsigned BIT_SW    = 4;
    localparam int unsigned BIT_FLASH = 6;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_RESET = 1'b1
    } rsc_state_e;

    function automatic logic [FLAG_W-1:0] flag_bit(input int unsigned pos);
        return FLAG_W'(1) << pos;
    endfunction

endpackage

// File: rtl/rsc_sync.sv
module rsc_sync #(
    parameter int unsigned      WIDTH   = 1,
    parameter int unsigned      STAGES  = 2,
    parameter logic [WIDTH-1:0] RST_VAL = '0
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [WIDTH-1:0] async_i,
    output logic [WIDTH-1:0] sync_o
);

    logic [WIDTH-1:0] stage_d [STAGES];
    logic [WIDTH-1:0] stage_q [STAGES];

    always_comb begin
        stage_d[0] = async_i;
        for (int i = 1; i < int'(STAGES); i++) begin
            stage_d[i] = stage_q[i-1];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            for (int i = 0; i < int'(STAGES); i++) begin
                stage_q[i] <= RST_VAL;
            end
        end else begin
            for (int i = 0; i < int'(STAGES); i++) begin
                stage_q[i] <= stage_d[i];
            end
        end
    end

    assign sync_o = stage_q[STAGES-1];

endmodule

// File: rtl/rsc_clk_monitor.sv
module rsc_clk_monitor #(
    parameter int unsigned LIMIT       = 25000,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic enable_i,
    input  logic mon_clk_i,
    output logic timeout_o
);

    localparam int unsigned CW = $clog2(LIMIT + 1);
    localparam logic [CW-1:0] LIMIT_C = CW'(LIMIT);

    typedef struct packed {
        logic          prev;
        logic [CW-1:0] cnt;
    } mon_t;

    mon_t m_d, m_q;
    logic mon_s;
    logic rise;

    rsc_sync #(
        .WIDTH  (1),
        .STAGES (SYNC_STAGES),
        .RST_VAL(1'b0)
    ) u_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(mon_clk_i),
        .sync_o (mon_s)
    );

    assign rise = mon_s & ~m_q.prev;

    always_comb begin
        m_d      = m_q;
        m_d.prev = mon_s;
        if (!enable_i || rise) begin
            m_d.cnt = '0;
        end else if (m_q.cnt != LIMIT_C) begin
            m_d.cnt = m_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            m_q <= '0;
        end else begin
            m_q <= m_d;
        end
    end

    assign timeout_o = enable_i && (m_q.cnt == LIMIT_C);

endmodule

// File: rtl/rsc_flash_guard.sv
module rsc_flash_guard #(
    parameter int unsigned       ADDR_W = 16,
    parameter logic [ADDR_W-1:0] TOP    = 16'h3DFF
) (
    input  logic              wr_i,
    input  logic              rd_i,
    input  logic              fetch_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              sec_i,
    output logic              err_o
);

    logic any_access;
    logic beyond;

    always_comb begin
        any_access = wr_i | rd_i | fetch_i;
        beyond     = addr_i > TOP;
        err_o      = (any_access && beyond) || sec_i;
    end

endmodule

// File: rtl/multi_reset_ctrl.sv
module multi_reset_ctrl
    import rsc_pkg::*;
#(
    parameter int unsigned       STRETCH_CYCLES = 16,
    parameter int unsigned       MCD_LIMIT      = 25000,
    parameter int unsigned       SYNC_STAGES    = 2,
    parameter int unsigned       ADDR_W         = 16,
    parameter logic [ADDR_W-1:0] FLASH_TOP      = 16'h3DFF
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              sys_clk_i,
    input  logic              pin_rst_ni,
    input  logic              reg_wr_i,
    input  logic [7:0]        reg_wdata_i,
    input  logic              fl_wr_i,
    input  logic              fl_rd_i,
    input  logic              fl_fetch_i,
    input  logic [ADDR_W-1:0] fl_addr_i,
    input  logic              fl_sec_i,
    input  logic              usb_bus_rst_i,
    input  logic              usb_vbus_i,
    input  logic              usb_vbus_pol_i,
    output logic              sys_rst_o,
    output logic [7:0]        status_o
);

    localparam int unsigned CNT_W = $clog2(STRETCH_CYCLES + 1);
    localparam logic [CNT_W-1:0] RELOAD = CNT_W'(STRETCH_CYCLES - 1);

    typedef struct packed {
        rsc_state_e         state;
        logic [CNT_W-1:0]   cnt;
        logic [FLAG_W-1:0]  flags;
        logic               mcd_en;
        logic               usb_en;
    } ctl_t;

    localparam ctl_t CTL_RESET = '{
        state:  ST_RESET,
        cnt:    RELOAD,
        flags:  '0,
        mcd_en: 1'b0,
        usb_en: 1'b0
    };

    ctl_t s_d, s_q;

    // Synchronised asynchronous inputs: {pin, bus reset, vbus}
    logic [2:0] async_in;
    logic [2:0] sync_out;
    logic       pin_low;
    logic       bus_rst_s;
    logic       vbus_s;

    assign async_in = {pin_rst_ni, usb_bus_rst_i, usb_vbus_i};

    rsc_sync #(
        .WIDTH  (3),
        .STAGES (SYNC_STAGES),
        .RST_VAL(3'b100)
    ) u_in_sync (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .async_i(async_in),
        .sync_o (sync_out)
    );

    assign pin_low   = ~sync_out[2];
    assign bus_rst_s = sync_out[1];
    assign vbus_s    = sync_out[0];

    logic mcd_timeout;

    rsc_clk_monitor #(
        .LIMIT      (MCD_LIMIT),
        .SYNC_STAGES(SYNC_STAGES)
    ) u_clk_mon (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .enable_i (s_q.mcd_en),
        .mon_clk_i(sys_clk_i),
        .timeout_o(mcd_timeout)
    );

    logic flash_err;

    rsc_flash_guard #(
        .ADDR_W(ADDR_W),
        .TOP   (FLASH_TOP)
    ) u_flash_guard (
        .wr_i   (fl_wr_i),
        .rd_i   (fl_rd_i),
        .fetch_i(fl_fetch_i),
        .addr_i (fl_addr_i),
        .sec_i  (fl_sec_i),
        .err_o  (flash_err)
    );

    // Only bits 2..4 of the write data carry meaning
    logic unused_wdata;
    assign unused_wdata = ^{reg_wdata_i[7:5], reg_wdata_i[1:0]};

    logic              usb_hit;
    logic              sw_hit;
    logic              any_hit;
    logic [FLAG_W-1:0] cause;

    // Fixed priority: pin, clock detector, flash, USB, software
    always_comb begin
        usb_hit = s_q.usb_en && (bus_rst_s || (vbus_s == usb_vbus_pol_i));
        sw_hit  = reg_wr_i && reg_wdata_i[BIT_SW];
        any_hit = 1'b1;
        if (pin_low) begin
            cause = flag_bit(BIT_PIN);
        end else if (mcd_timeout) begin
            cause = flag_bit(BIT_MCD);
        end else if (flash_err) begin
            cause = flag_bit(BIT_FLASH);
        end else if (usb_hit) begin
            cause = flag_bit(BIT_USB);
        end else if (sw_hit) begin
            cause = flag_bit(BIT_SW);
        end else begin
            cause   = '0;
            any_hit = 1'b0;
        end
    end

    always_comb begin
        s_d = s_q;
        unique case (s_q.state)
            ST_IDLE: begin
                if (any_hit) begin
                    s_d.state  = ST_RESET;
                    s_d.cnt    = RELOAD;
                    s_d.flags  = cause;
                    s_d.mcd_en = 1'b0;
                    s_d.usb_en = 1'b0;
                end else if (reg_wr_i) begin
                    s_d.mcd_en = reg_wdata_i[BIT_MCD];
                    s_d.usb_en = reg_wdata_i[BIT_USB];
                end
            end
            ST_RESET: begin
                if (pin_low) begin
                    s_d.cnt   = RELOAD;
                    s_d.flags = flag_bit(BIT_PIN);
                end else if (s_q.cnt == '0) begin
                    s_d.state = ST_IDLE;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            default: s_d = CTL_RESET;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            s_q <= CTL_RESET;
        end else begin
            s_q <= s_d;
        end
    end

    assign sys_rst_o = (s_q.state == ST_RESET);
    assign status_o  = s_q.flags;

endmodule

// File: rtl/multi_reset_ctrl_chk.sv
module multi_reset_ctrl_chk #(
    parameter int unsigned STRETCH_CYCLES = 16
) (
    input logic       clk_i,
    input logic       rst_ni,
    input logic       pin_rst_ni,
    input logic       reg_wr_i,
    input logic [7:0] reg_wdata_i,
    input logic       fl_sec_i,
    input logic       sys_rst_o,
    input logic [7:0] status_o
);

    logic [15:0] hi_cnt_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            hi_cnt_q <= '0;
        end else if (sys_rst_o) begin
            if (hi_cnt_q != 16'hFFFF) hi_cnt_q <= hi_cnt_q + 16'd1;
        end else begin
            hi_cnt_q <= '0;
        end
    end

    AST_MIN_WIDTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(sys_rst_o) |-> (32'(hi_cnt_q) >= STRETCH_CYCLES)); // R3

    AST_PIN_FORCES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($past(pin_rst_ni, 3) == 1'b0) |-> sys_rst_o); // R2

    AST_SW_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sys_rst_o && reg_wr_i && reg_wdata_i[4]) |=> sys_rst_o); // R3

    AST_SEC_FIRES: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!sys_rst_o && fl_sec_i) |=> sys_rst_o); // R4

    AST_ONE_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(status_o)); // R7

    AST_STATUS_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !$stable(status_o) |-> sys_rst_o); // R7

endmodule

bind multi_reset_ctrl multi_reset_ctrl_chk #(
    .STRETCH_CYCLES(STRETCH_CYCLES)
) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .pin_rst_ni (pin_rst_ni),
    .reg_wr_i   (reg_wr_i),
    .reg_wdata_i(reg_wdata_i),
    .fl_sec_i   (fl_sec_i),
    .sys_rst_o  (sys_rst_o),
    .status_o   (status_o)
);

// File: tb/multi_reset_ctrl_tb.sv
module multi_reset_ctrl_tb;

    localparam int STRETCH = 8;
    localparam int LIMIT   = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sys_clk = 1'b0;
    logic        sys_run = 1'b1;
    logic        pin_n = 1'b1;
    logic        reg_wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic        fwr = 1'b0, frd = 1'b0, ffe = 1'b0, fsec = 1'b0;
    logic [15:0] faddr = '0;
    logic        bus_rst = 1'b0, vbus = 1'b0, vbus_pol = 1'b1;
    logic        sys_rst;
    logic [7:0]  status;

    int checks = 0;
    int failures = 0;

    always #2 clk = ~clk;

    initial begin
        #1;
        forever begin
            #20;
            if (sys_run) sys_clk = ~sys_clk;
        end
    end

    multi_reset_ctrl #(
        .STRETCH_CYCLES(STRETCH),
        .MCD_LIMIT     (LIMIT)
    ) u_dut (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .sys_clk_i     (sys_clk),
        .pin_rst_ni    (pin_n),
        .reg_wr_i      (reg_wr),
        .reg_wdata_i   (wdata),
        .fl_wr_i       (fwr),
        .fl_rd_i       (frd),
        .fl_fetch_i    (ffe),
        .fl_addr_i     (faddr),
        .fl_sec_i      (fsec),
        .usb_bus_rst_i (bus_rst),
        .usb_vbus_i    (vbus),
        .usb_vbus_pol_i(vbus_pol),
        .sys_rst_o     (sys_rst),
        .status_o      (status)
    );

    typedef struct packed {
        logic        wr;
        logic [7:0]  wd;
        logic        fwr;
        logic        frd;
        logic        ffe;
        logic [15:0] addr;
        logic        sec;
        logic        exp_rst;
        logic [7:0]  exp_st;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VECS [NV] = '{
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 16'h3E00, 1'b0, 1'b1, 8'h40},
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 16'hFFFF, 1'b0, 1'b1, 8'h40},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 16'h3E00, 1'b0, 1'b1, 8'h40},
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 16'h3DFF, 1'b0, 1'b0, 8'h40},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b1, 1'b1, 8'h40},
        '{1'b1, 8'h10, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b1, 8'h10},
        '{1'b1, 8'h41, 1'b0, 1'b0, 1'b0, 16'h0000, 1'b0, 1'b0, 8'h10},
        '{1'b1, 8'h50, 1'b0, 1'b0, 1'b1, 16'h3E00, 1'b0, 1'b1, 8'h40},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 16'h0000, 1'b0, 1'b0, 8'h40}
    };

    function automatic string tag_of(input int i);
        case (i)
            5:       return "R3";
            6:       return "R7";
            7:       return "R8";
            default: return "R4";
        endcase
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_idle();
        for (int n = 0; n < 1000 && sys_rst; n++) @(negedge clk);
    endtask

    task automatic do_write(input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1;
        wdata  = d;
        @(negedge clk);
        reg_wr = 1'b0;
        wdata  = '0;
    endtask

    task automatic watch(input int n, output int highs);
        highs = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (sys_rst) highs++;
        end
    endtask

    task automatic count_high(output int n);
        n = 0;
        for (int k = 0; k < 1000 && sys_rst; k++) begin
            n++;
            @(negedge clk);
        end
    endtask

    initial begin
        #400000;
        failures++;
        $display("FAIL watchdog actual=0x0 expected=0x1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int n;
        int highs;

        // R1: power-on reset width and cleared status
        repeat (3) @(negedge clk);
        check(sys_rst == 1'b1, "R1 held in reset", int'(sys_rst), 1);
        rst_n = 1'b1;
        count_high(n);
        check(n == STRETCH, "R1 power-on width", n, STRETCH);
        check(status == 8'h00, "R1 status after power-on", int'(status), 0);

        // Table: flash, software, ignored writes, priority
        for (int i = 0; i < NV; i++) begin
            wait_idle();
            @(negedge clk);
            reg_wr = VECS[i].wr;
            wdata  = VECS[i].wd;
            fwr    = VECS[i].fwr;
            frd    = VECS[i].frd;
            ffe    = VECS[i].ffe;
            faddr  = VECS[i].addr;
            fsec   = VECS[i].sec;
            @(negedge clk);
            reg_wr = 1'b0; wdata = '0; fwr = 1'b0; frd = 1'b0;
            ffe = 1'b0; fsec = 1'b0; faddr = '0;
            check(sys_rst == VECS[i].exp_rst, tag_of(i), int'(sys_rst), int'(VECS[i].exp_rst));
            repeat (2 * STRETCH + 4) @(negedge clk);
            check(sys_rst == 1'b0, tag_of(i), int'(sys_rst), 0);
            check(status == VECS[i].exp_st, tag_of(i), int'(status), int'(VECS[i].exp_st));
        end

        // R3: software reset lasts exactly STRETCH cycles
        wait_idle();
        do_write(8'h10);
        count_high(n);
        check(n == STRETCH, "R3 software width", n, STRETCH);
        check(status == 8'h10, "R3 software status", int'(status), 8'h10);

        // R2: pin reset held while low, stretched after release
        @(negedge clk);
        pin_n = 1'b0;
        repeat (30) @(negedge clk);
        check(sys_rst == 1'b1, "R2 held while pin low", int'(sys_rst), 1);
        check(status == 8'h01, "R2 pin status", int'(status), 1);
        pin_n = 1'b1;
        count_high(n);
        check(n >= STRETCH && n <= STRETCH + 4, "R2 release width", n, STRETCH);

        // R8: pin during a software reset overrides the cause
        wait_idle();
        do_write(8'h10);
        pin_n = 1'b0;
        repeat (5) @(negedge clk);
        pin_n = 1'b1;
        wait_idle();
        check(status == 8'h01, "R8 pin overrides software", int'(status), 1);

        // R5: armed detector with running clock stays quiet, then fires
        wait_idle();
        do_write(8'h04);
        watch(150, highs);
        check(highs == 0, "R5 running clock no reset", highs, 0);
        sys_run = 1'b0;
        watch(LIMIT + 10, highs);
        check(highs > 0, "R5 stopped clock reset", highs, 1);
        wait_idle();
        check(status == 8'h04, "R5 detector status", int'(status), 4);

        // R9: detector disarmed by the reset it caused
        watch(3 * LIMIT, highs);
        check(highs == 0, "R9 no repeat after detector reset", highs, 0);

        // R5: writing 0 to bit 2 disarms
        sys_run = 1'b1;
        repeat (20) @(negedge clk);
        do_write(8'h04);
        do_write(8'h00);
        sys_run = 1'b0;
        watch(3 * LIMIT, highs);
        check(highs == 0, "R5 disarmed detector", highs, 0);

        // R10: arming write during reset is ignored
        pin_n = 1'b0;
        repeat (5) @(negedge clk);
        do_write(8'h04);
        pin_n = 1'b1;
        wait_idle();
        watch(3 * LIMIT, highs);
        check(highs == 0, "R10 write during reset ignored", highs, 0);
        sys_run = 1'b1;
        repeat (20) @(negedge clk);

        // R6: unarmed USB inputs have no effect
        @(negedge clk);
        bus_rst = 1'b1;
        watch(8, highs);
        bus_rst = 1'b0;
        check(highs == 0, "R6 unarmed bus reset", highs, 0);
        check(status == 8'h01, "R6 status unchanged", int'(status), 1);

        // R6: armed bus reset
        do_write(8'h08);
        @(negedge clk);
        bus_rst = 1'b1;
        repeat (4) @(negedge clk);
        bus_rst = 1'b0;
        check(sys_rst == 1'b1, "R6 bus reset fires", int'(sys_rst), 1);
        wait_idle();
        check(status == 8'h08, "R6 bus reset status", int'(status), 8);

        // R6: armed VBUS polarity match
        do_write(8'h08);
        @(negedge clk);
        vbus = 1'b1;
        watch(5, highs);
        check(highs > 0, "R6 vbus match fires", highs, 1);
        vbus = 1'b0;
        wait_idle();
        check(status == 8'h08, "R6 vbus status", int'(status), 8);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule